// File: doc/BRIEF.md
# Memory Access Region Predictor

This block sits at dispatch in a wide-issue core that has two memory pipelines: one for local stack-frame traffic and one for everything else. For every load or store it guesses, from the instruction address and the calling context, whether the access will fall in the stack region. The guess then picks the pipeline that receives the instruction before it reaches the reservation stations.

The guess is read from a table of one-bit entries. The table is indexed by the word-address bits of the PC XORed with the low global branch history bits and a call-site identifier. The dispatch logic keeps the index that the block returns and carries it with the instruction. After address translation, the page attributes give the true region. The block then receives the saved index, the bit it predicted and the true bit. On a mismatch it raises a reissue flag for that access and writes the true bit into the entry. A compiler hint, when it is present, takes the place of the table for that lookup.

Top module: `region_predictor`

## Requirements
- R1: After reset every entry holds 0 (non-stack, the conventional cache path), so any unhinted lookup that has not been trained returns `pred_stack` = 0.
- R2: `pred_idx` equals `lk_pc[IDX_W+1:2] ^ lk_hist[IDX_W-1:0] ^ lk_site[IDX_W-1:0]`, where narrower context fields are zero-extended. PC bits above `IDX_W+1` and the two byte-offset bits have no effect, and different contexts that fold to the same index share one entry.
- R3: With `lk_valid` = 1 and `lk_hint_valid` = 0, `pred_stack` is the entry at `pred_idx` (1 = stack, 0 = non-stack). With `lk_valid` = 0, `pred_stack` is 0.
- R4: With `lk_hint_valid` = 1, `pred_stack` equals `lk_hint_stack` whatever the entry holds, and a hinted lookup never changes the table.
- R5: `reissue` is 1 in the same cycle exactly when `vf_valid` = 1 and `vf_pred` differs from `vf_actual`, and it is 0 otherwise.
- R6: A mismatching verification writes `vf_actual` into entry `vf_idx` at the clock edge, so an unhinted lookup of that index in the next cycle returns the true bit.
- R7: A verification whose prediction was correct, or one with `vf_valid` = 0, leaves every entry unchanged.
- R8: When a mismatching verification and an unhinted lookup hit the same index in the same cycle, the lookup returns `vf_actual`.
- R9: `pred_valid` follows `lk_valid` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | A memory instruction is being dispatched |
| lk_pc | input | PC_W | Instruction address |
| lk_hist | input | HIST_W | Global branch history |
| lk_site | input | SITE_W | Call-site identifier |
| lk_hint_valid | input | 1 | A compiler region hint is present |
| lk_hint_stack | input | 1 | Hinted region, 1 = stack |
| pred_valid | output | 1 | Prediction is valid |
| pred_stack | output | 1 | Predicted region, 1 = stack pipeline |
| pred_idx | output | IDX_W | Table index, kept with the instruction |
| vf_valid | input | 1 | A translated access reports its region |
| vf_idx | input | IDX_W | Index saved at dispatch |
| vf_pred | input | 1 | Region that was predicted |
| vf_actual | input | 1 | Region from the page attributes |
| reissue | output | 1 | Prediction was wrong; the access must be reissued |

## Verification
The bench builds the block with 16 entries, a 16-bit PC and 4-bit history and call-site fields. With 16 entries every index can be worked out by hand, and two different PC and context pairs can be made to fold onto one entry, so the sharing in R2 can be exercised. Upper PC bits still lie outside the index, so the bench can show that they have no effect. At this size the same-cycle collision of a write and a read, and the clearing of trained entries by a second reset, can also be reached in a few cycles.

// File: rtl/region_predictor.sv
module region_predictor #(
  parameter int ENTRIES = 1024,
  parameter int PC_W    = 32,
  parameter int HIST_W  = 12,
  parameter int SITE_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [PC_W-1:0]   lk_pc,
  input  logic [HIST_W-1:0] lk_hist,
  input  logic [SITE_W-1:0] lk_site,
  input  logic              lk_hint_valid,
  input  logic              lk_hint_stack,
  output logic              pred_valid,
  output logic              pred_stack,
  output logic [IDX_W-1:0]  pred_idx,
  input  logic              vf_valid,
  input  logic [IDX_W-1:0]  vf_idx,
  input  logic              vf_pred,
  input  logic              vf_actual,
  output logic              reissue
);

  logic [ENTRIES-1:0] tbl;
  logic [IDX_W-1:0]   pc_bits, hist_bits, site_bits;
  logic               wr_en, fwd, entry;

  assign pc_bits   = lk_pc[IDX_W+1:2];
  assign hist_bits = IDX_W'(lk_hist);
  assign site_bits = IDX_W'(lk_site);
  assign pred_idx  = pc_bits ^ hist_bits ^ site_bits;

  assign wr_en   = vf_valid && (vf_pred != vf_actual);
  assign reissue = wr_en;

  assign fwd   = wr_en && (vf_idx == pred_idx);
  assign entry = fwd ? vf_actual : tbl[pred_idx];

  assign pred_valid = lk_valid;
  assign pred_stack = lk_valid && (lk_hint_valid ? lk_hint_stack : entry);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tbl <= '0;
    else if (wr_en)
      tbl[vf_idx] <= vf_actual;
  end

endmodule

// File: rtl/region_predictor_chk.sv
module region_predictor_chk #(
  parameter int IDX_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             lk_hint_valid,
  input logic             lk_hint_stack,
  input logic             pred_valid,
  input logic             pred_stack,
  input logic [IDX_W-1:0] pred_idx,
  input logic             vf_valid,
  input logic [IDX_W-1:0] vf_idx,
  input logic             vf_pred,
  input logic             vf_actual,
  input logic             reissue
);

  logic live;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  AST_FRESH_NON_STACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!live && lk_valid && !lk_hint_valid && !vf_valid) |-> !pred_stack); // R1

  AST_HINT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_hint_valid) |-> (pred_stack == lk_hint_stack)); // R4

  AST_NO_IDLE_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    !vf_valid |-> !reissue); // R5

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!pred_stack && !pred_valid)); // R3

  AST_TRAINED_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(reissue) && lk_valid && !lk_hint_valid &&
     pred_idx == $past(vf_idx) && !(vf_valid && vf_idx == pred_idx))
    |-> (pred_stack == $past(vf_actual))); // R6

  AST_COLLIDE_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_hint_valid && reissue && vf_idx == pred_idx)
    |-> (pred_stack == vf_actual)); // R8

endmodule

bind region_predictor region_predictor_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_hint_valid(lk_hint_valid),
  .lk_hint_stack(lk_hint_stack), .pred_valid(pred_valid), .pred_stack(pred_stack),
  .pred_idx(pred_idx), .vf_valid(vf_valid), .vf_idx(vf_idx), .vf_pred(vf_pred),
  .vf_actual(vf_actual), .reissue(reissue)
);

// File: tb/region_predictor_bench.sv
module region_predictor_bench;
  localparam int ENTRIES = 16;
  localparam int PC_W = 16;
  localparam int HW = 4;
  localparam int SW = 4;
  localparam int IW = 4;

  typedef struct packed {
    logic          lv;
    logic [15:0]   pc;
    logic [3:0]    hist;
    logic [3:0]    site;
    logic          hv;
    logic          hs;
    logic          vv;
    logic [3:0]    vidx;
    logic          vp;
    logic          va;
    logic          e_pred;
    logic [3:0]    e_idx;
    logic          e_re;
  } vec_t;

  // lv pc hist site hv hs vv vidx vp va | e_pred e_idx e_re
  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 16'h0010, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 4'h4, 1'b0}, // R1 R2
    '{1'b1, 16'h0020, 4'h1, 4'h0, 1'b0, 1'b0, 1'b1, 4'h4, 1'b0, 1'b1, 1'b0, 4'h9, 1'b1}, // R5 write idx4=1
    '{1'b1, 16'h0010, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, 4'h4, 1'b1, 1'b1, 1'b1, 4'h4, 1'b0}, // R6 R7
    '{1'b1, 16'hF013, 4'h3, 4'h3, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 4'h4, 1'b0}, // R2 R7 aliasing
    '{1'b1, 16'h0020, 4'h1, 4'h0, 1'b0, 1'b0, 1'b1, 4'h9, 1'b0, 1'b1, 1'b1, 4'h9, 1'b1}, // R8 collide
    '{1'b1, 16'h0024, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, 4'h4, 1'b1, 1'b0, 1'b1, 4'h9, 1'b1}, // R2 R6
    '{1'b1, 16'h0010, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 4'h4, 1'b0}, // R6 cleared
    '{1'b1, 16'h0024, 4'h0, 4'h0, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 4'h9, 1'b0}, // R4 hint 0
    '{1'b1, 16'h0010, 4'h0, 4'h0, 1'b1, 1'b1, 1'b0, 4'h4, 1'b1, 1'b0, 1'b1, 4'h4, 1'b0}, // R4 R5 R7
    '{1'b1, 16'h003C, 4'hF, 4'h5, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 4'h5, 1'b0}  // R3 untrained
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0, lk_hint_valid = 1'b0, lk_hint_stack = 1'b0;
  logic [PC_W-1:0] lk_pc = '0;
  logic [HW-1:0] lk_hist = '0;
  logic [SW-1:0] lk_site = '0;
  logic vf_valid = 1'b0, vf_pred = 1'b0, vf_actual = 1'b0;
  logic [IW-1:0] vf_idx = '0;
  logic pred_valid, pred_stack, reissue;
  logic [IW-1:0] pred_idx;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  region_predictor #(.ENTRIES(ENTRIES), .PC_W(PC_W), .HIST_W(HW), .SITE_W(SW)) u_region_predictor (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_hist(lk_hist),
    .lk_site(lk_site), .lk_hint_valid(lk_hint_valid), .lk_hint_stack(lk_hint_stack),
    .pred_valid(pred_valid), .pred_stack(pred_stack), .pred_idx(pred_idx),
    .vf_valid(vf_valid), .vf_idx(vf_idx), .vf_pred(vf_pred), .vf_actual(vf_actual),
    .reissue(reissue)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    lk_valid = v.lv; lk_pc = v.pc; lk_hist = v.hist; lk_site = v.site;
    lk_hint_valid = v.hv; lk_hint_stack = v.hs;
    vf_valid = v.vv; vf_idx = v.vidx; vf_pred = v.vp; vf_actual = v.va;
    #3;
  endtask

  function automatic vec_t look(input logic [15:0] pc, input logic [3:0] h, input logic [3:0] s,
                                input logic hv, input logic hs);
    vec_t v = '0;
    v.lv = 1'b1; v.pc = pc; v.hist = h; v.site = s; v.hv = hv; v.hs = hs;
    return v;
  endfunction

  initial begin
    #200000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    vec_t v;
    // R1 R2 R9: during reset, a lookup reads non-stack with the folded index
    v = look(16'h0034, 4'h2, 4'h1, 1'b0, 1'b0);
    drive(v);
    chk("R1 reset pred", pred_stack, 0);
    chk("R2 reset idx", pred_idx, 4'hD ^ 4'h2 ^ 4'h1);
    chk("R9 valid", pred_valid, 1);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      chk($sformatf("R3 vec%0d pred", i), pred_stack, VEC[i].e_pred);
      chk($sformatf("R2 vec%0d idx", i), pred_idx, VEC[i].e_idx);
      chk($sformatf("R5 vec%0d reissue", i), reissue, VEC[i].e_re);
    end

    // R9 R3: idle lookup gives no prediction
    v = '0;
    drive(v);
    chk("R9 idle valid", pred_valid, 0);
    chk("R3 idle pred", pred_stack, 0);

    // R4: hinted stack lookup of idx 5 leaves entry untouched
    v = look(16'h0014, 4'h0, 4'h0, 1'b1, 1'b1);
    drive(v);
    chk("R4 hinted", pred_stack, 1);
    v = look(16'h0014, 4'h0, 4'h0, 1'b0, 1'b0);
    drive(v);
    chk("R4 no train", pred_stack, 0);

    // R7: matching verify of idx 5 with both bits 1 does not write
    v = '0; v.vv = 1'b1; v.vidx = 4'h5; v.vp = 1'b1; v.va = 1'b1;
    drive(v);
    chk("R7 no reissue", reissue, 0);
    v = look(16'h0014, 4'h0, 4'h0, 1'b0, 1'b0);
    drive(v);
    chk("R7 entry kept", pred_stack, 0);

    // R8: collision that clears idx 9 (currently 1)
    v = look(16'h0024, 4'h0, 4'h0, 1'b0, 1'b0);
    v.vv = 1'b1; v.vidx = 4'h9; v.vp = 1'b1; v.va = 1'b0;
    drive(v);
    chk("R8 collide clear", pred_stack, 0);
    chk("R5 collide reissue", reissue, 1);
    // retrain idx 9 to 1, then reset must clear it
    v = '0; v.vv = 1'b1; v.vidx = 4'h9; v.vp = 1'b0; v.va = 1'b1;
    drive(v);
    v = look(16'h0024, 4'h0, 4'h0, 1'b0, 1'b0);
    drive(v);
    chk("R6 retrained", pred_stack, 1);
    rst_n = 1'b0;
    #1;
    chk("R1 reset clears", pred_stack, 0);
    @(negedge clk); rst_n = 1'b1;
    #3;
    chk("R1 after reset", pred_stack, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule